// File: doc/BRIEF.md
# Flash Sector Write-Protection Gate

This block sits between the bus-control pins of a flash-style memory and the engine that runs program and erase cycles. It decides, one request at a time, whether a program or erase may begin. The decision takes in a lock flag kept for every sector, a high-voltage override flag, program-inhibit rules on the chip-enable, write-enable and output-enable pins, a filter that drops short write strobes, and a hold-off time that starts when the supply-good flag rises. The operation code comes from an external command decoder as a small code. Analog sensing is reduced to the `supplyOk` and `hvOverride` flags.

A write cycle is seen as chip enable low, write enable low and output enable high, all held for consecutive clock cycles. When the cycle has lasted `GLITCH_CYC` clocks, the block judges it once. For a program, sector-erase or chip-erase code that passes every rule, `startEn` pulses high for one clock. A lock code instead sets the lock flag of the addressed sector. In identification mode, a read at word offset 2 inside a sector returns that sector's lock flag.

Top module: `flash_wp_gate`

## Requirements
- R1: After reset `startEn` and `statusValid` are 0, every sector lock flag is clear, and identification mode is off.
- R2: A write cycle exists only while `ceN`=0, `weN`=0 and `oeN`=1 hold together. If `oeN` goes low or `ceN`/`weN` go high, the cycle ends and the glitch count restarts, so the cycle cannot start an operation.
- R3: A write cycle shorter than `GLITCH_CYC` clocks never starts anything. A cycle of `GLITCH_CYC` clocks or longer is judged exactly once. An accepted operation gives a single-clock `startEn` pulse in the clock after the `GLITCH_CYC`-th active clock edge.
- R4: While `supplyOk` is 0, no operation starts and no lock flag is set.
- R5: After `supplyOk` rises, operations and lock commands stay refused for `PWRON_CYC` clocks.
- R6: Lock code 4 (`opKind`=3'd4) sets the lock flag of the sector given by the upper `addr` bits (above the `OFF_W` offset bits). Only reset clears lock flags. A lock command never raises `startEn`.
- R7: Word program (code 1) and sector erase (code 2) to a locked sector are refused unless `hvOverride` is 1. To an unlocked sector they are accepted.
- R8: Chip erase (code 3) is refused outright if any sector is locked and `hvOverride` is 0. Otherwise it is accepted.
- R9: `hvOverride` is sampled at the clock edge that judges the cycle. If it drops at that edge, the request is refused at once.
- R10: An `idEnter` pulse enables identification mode. In that mode a read (`ceN`=0, `oeN`=0) at offset 2 gives `statusValid`=1 one clock later, with `statusLock` set to the sector's lock flag (0 = programmable, 1 = locked). Other offsets give `statusValid`=0.
- R11: An `idExit` pulse returns to normal reads, after which `statusValid` stays 0. Codes 0 and 5 to 7 never start anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | SEC_W+OFF_W | Word address: sector above, offset below |
| opKind | input | 3 | Decoded operation code (0 none, 1 program, 2 sector erase, 3 chip erase, 4 lock) |
| idEnter | input | 1 | Enter identification mode (pulse) |
| idExit | input | 1 | Leave identification mode (pulse) |
| supplyOk | input | 1 | Supply above sense level |
| hvOverride | input | 1 | High-voltage lockout override |
| startEn | output | 1 | One-clock permission to start program/erase |
| statusValid | output | 1 | Identification read of the lock flag is valid |
| statusLock | output | 1 | Lock flag of the read sector |
| lockBits | output | NUM_SECTORS | Current sector lock flags |

## Verification
Two things can land on the same clock edge: the glitch filter qualifying a write cycle, and a change of `hvOverride` or `supplyOk`. The bench provokes this by changing the flag in the half-cycle just before the qualifying edge. It expects the value seen at that edge to decide the request: a dropped override refuses a locked-sector program, and a raised one admits it. A lock command and a later override-free program to the same sector are also mixed into the random traffic, so the bench model's lock state must track the design's lock state cycle by cycle.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_SERASE = 3'd2,
    OP_CERASE = 3'd3,
    OP_LOCK   = 3'd4
  } opKind_t;

  typedef struct packed {
    logic wrQual;    // write cycle just survived the glitch filter
    logic pwrReady;  // supply good and hold-off expired
    logic idRead;    // identification read of the lock word
  } ctrlStrobes_t;

  localparam int unsigned ID_LOCK_OFFSET = 2;
endpackage

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int unsigned OFF_W      = 3,
  parameter int unsigned GLITCH_CYC = 2,
  parameter int unsigned PWRON_CYC  = 1000000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ceN,
  input  logic               weN,
  input  logic               oeN,
  input  logic [OFF_W-1:0]   offset,
  input  logic               supplyOk,
  input  logic               idEnter,
  input  logic               idExit,
  output ctrlStrobes_t       strobes
);
  localparam int unsigned GW = $clog2(GLITCH_CYC + 1);
  localparam int unsigned PW = $clog2(PWRON_CYC + 1);
  localparam logic [GW-1:0] G_LAST = GW'(GLITCH_CYC - 1);
  localparam logic [GW-1:0] G_SAT  = GW'(GLITCH_CYC);
  localparam logic [PW-1:0] P_DONE = PW'(PWRON_CYC);

  logic [GW-1:0] glitchCnt;
  logic [PW-1:0] pwrCnt;
  logic          idMode;
  logic          wrActive;

  assign wrActive = !ceN && !weN && oeN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      glitchCnt <= '0;
    end else if (!wrActive) begin
      glitchCnt <= '0;
    end else if (glitchCnt != G_SAT) begin
      glitchCnt <= glitchCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !supplyOk) begin
      pwrCnt <= '0;
    end else if (pwrCnt != P_DONE) begin
      pwrCnt <= pwrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idMode <= 1'b0;
    end else if (idExit) begin
      idMode <= 1'b0;
    end else if (idEnter) begin
      idMode <= 1'b1;
    end
  end

  always_comb begin
    strobes.wrQual   = wrActive && (glitchCnt == G_LAST);
    strobes.pwrReady = supplyOk && (pwrCnt == P_DONE);
    strobes.idRead   = idMode && !ceN && !oeN &&
                       (offset == OFF_W'(ID_LOCK_OFFSET));
  end
endmodule

// File: rtl/flash_wp_data.sv
module flash_wp_data
  import flash_wp_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned SEC_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [2:0]             opKind,
  input  logic [SEC_W-1:0]       sector,
  input  logic                   hvOverride,
  output logic                   startEn,
  output logic                   statusValid,
  output logic                   statusLock,
  output logic [NUM_SECTORS-1:0] lockBits
);
  logic secLocked;
  logic anyLocked;
  logic opAllowed;
  logic doLock;

  assign secLocked = lockBits[sector];
  assign anyLocked = |lockBits;
  assign doLock    = strobes.wrQual && strobes.pwrReady && (opKind == OP_LOCK);

  always_comb begin
    unique case (opKind)
      OP_PROG, OP_SERASE: opAllowed = hvOverride || !secLocked;
      OP_CERASE:          opAllowed = hvOverride || !anyLocked;
      default:            opAllowed = 1'b0;
    endcase
  end

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lockBits[s] <= 1'b0;
      end else if (doLock && (sector == SEC_W'(s))) begin
        lockBits[s] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startEn     <= 1'b0;
      statusValid <= 1'b0;
      statusLock  <= 1'b0;
    end else begin
      startEn     <= strobes.wrQual && strobes.pwrReady && opAllowed;
      statusValid <= strobes.idRead;
      statusLock  <= strobes.idRead && secLocked;
    end
  end
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import flash_wp_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned OFF_W       = 3,
  parameter int unsigned GLITCH_CYC  = 2,
  parameter int unsigned PWRON_CYC   = 1000000,
  localparam int unsigned SEC_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int unsigned AW         = SEC_W + OFF_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ceN,
  input  logic                   weN,
  input  logic                   oeN,
  input  logic [AW-1:0]          addr,
  input  logic [2:0]             opKind,
  input  logic                   idEnter,
  input  logic                   idExit,
  input  logic                   supplyOk,
  input  logic                   hvOverride,
  output logic                   startEn,
  output logic                   statusValid,
  output logic                   statusLock,
  output logic [NUM_SECTORS-1:0] lockBits
);
  ctrlStrobes_t strobes;

  flash_wp_ctrl #(
    .OFF_W(OFF_W), .GLITCH_CYC(GLITCH_CYC), .PWRON_CYC(PWRON_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .offset(addr[OFF_W-1:0]), .supplyOk(supplyOk),
    .idEnter(idEnter), .idExit(idExit), .strobes(strobes)
  );

  flash_wp_data #(
    .NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opKind(opKind),
    .sector(addr[AW-1:OFF_W]), .hvOverride(hvOverride),
    .startEn(startEn), .statusValid(statusValid),
    .statusLock(statusLock), .lockBits(lockBits)
  );
endmodule

// File: rtl/flash_wp_gate_chk.sv
module flash_wp_gate_chk #(
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned OFF_W       = 3,
  parameter int unsigned PWRON_CYC   = 1000000,
  parameter int unsigned AW          = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   ceN,
  input logic                   oeN,
  input logic [AW-1:0]          addr,
  input logic [2:0]             opKind,
  input logic                   supplyOk,
  input logic                   hvOverride,
  input logic                   startEn,
  input logic                   statusValid,
  input logic [NUM_SECTORS-1:0] lockBits
);
  localparam int unsigned RW = $clog2(PWRON_CYC + 2);
  logic [RW-1:0] okRun;

  always_ff @(posedge clk) begin
    if (!rstN || !supplyOk) okRun <= '0;
    else if (okRun != RW'(PWRON_CYC + 1)) okRun <= okRun + 1'b1;
  end

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    startEn |=> !startEn);

  p_oe_inhibit_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(oeN) |-> !startEn);

  p_ce_inhibit_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(ceN) |-> !startEn);

  p_supply_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(supplyOk) |-> !startEn);

  p_holdoff_r5: assert property (@(posedge clk) disable iff (!rstN)
    startEn |-> (okRun >= RW'(PWRON_CYC + 1)));

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((~$past(lockBits) | lockBits) == '1));

  p_sector_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startEn && ($past(opKind) != 3'd3)) |->
      ($past(hvOverride) || !$past(lockBits[addr[AW-1:OFF_W]])));

  p_chip_erase_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startEn && ($past(opKind) == 3'd3)) |->
      ($past(hvOverride) || ($past(lockBits) == '0)));

  p_id_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> ($past(!ceN) && $past(!oeN)));
endmodule

bind flash_wp_gate flash_wp_gate_chk #(
  .NUM_SECTORS(NUM_SECTORS), .OFF_W(OFF_W), .PWRON_CYC(PWRON_CYC), .AW(AW)
) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .addr(addr),
  .opKind(opKind), .supplyOk(supplyOk), .hvOverride(hvOverride),
  .startEn(startEn), .statusValid(statusValid), .lockBits(lockBits)
);

// File: tb/tb_flash_wp_gate.sv
module tb_flash_wp_gate;
  localparam int NS = 4;
  localparam int OW = 3;
  localparam int GC = 3;
  localparam int PC = 40;
  localparam int SW = 2;
  localparam int AW = SW + OW;

  logic clk = 0, rstN = 0;
  logic ceN = 1, weN = 1, oeN = 1;
  logic [AW-1:0] addr = '0;
  logic [2:0] opKind = 3'd0;
  logic idEnter = 0, idExit = 0, supplyOk = 1, hvOverride = 0;
  logic startEn, statusValid, statusLock;
  logic [NS-1:0] lockBits;

  int checks = 0, errors = 0, startCnt = 0;
  bit modelLock [NS];
  bit done = 0;

  flash_wp_gate #(.NUM_SECTORS(NS), .OFF_W(OW), .GLITCH_CYC(GC), .PWRON_CYC(PC)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .opKind(opKind), .idEnter(idEnter), .idExit(idExit), .supplyOk(supplyOk),
    .hvOverride(hvOverride), .startEn(startEn), .statusValid(statusValid),
    .statusLock(statusLock), .lockBits(lockBits));

  always #5 clk = ~clk;

  always @(negedge clk) if (startEn) startCnt++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit anyModelLock();
    for (int i = 0; i < NS; i++) if (modelLock[i]) return 1;
    return 0;
  endfunction

  function automatic int expStarts(int op, int sec, int len, bit ovr);
    if (len < GC) return 0;
    case (op)
      1, 2: return (ovr || !modelLock[sec]) ? 1 : 0;
      3:    return (ovr || !anyModelLock()) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  // dropAt >= 0: toggle override to newOvr after dropAt active cycles
  task automatic busWrite(int op, int sec, int off, int len, int dropAt, bit newOvr);
    startCnt = 0;
    opKind = 3'(op); addr = {SW'(sec), OW'(off)};
    ceN = 0; weN = 0; oeN = 1;
    for (int i = 0; i < len; i++) begin
      if (i == dropAt) hvOverride = newOvr;
      @(negedge clk);
    end
    ceN = 1; weN = 1; opKind = 3'd0;
    repeat (3) @(negedge clk);
  endtask

  task automatic idRead(int sec, int off, output bit v, output bit l);
    addr = {SW'(sec), OW'(off)}; ceN = 0; oeN = 0; weN = 1;
    @(negedge clk);
    v = statusValid; l = statusLock;
    ceN = 1; oeN = 1;
    @(negedge clk);
  endtask

  task automatic pulse(input bit isEnter);
    if (isEnter) idEnter = 1; else idExit = 1;
    @(negedge clk);
    idEnter = 0; idExit = 0;
  endtask

  initial begin
    bit v, l;
    int e, op, sec, len;
    bit ovr;
    void'($urandom(32'd1234));
    for (int i = 0; i < NS; i++) modelLock[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 startEn", startEn, 0);
    check("R1 statusValid", statusValid, 0);
    check("R1 lockBits", lockBits, 0);
    rstN = 1;
    repeat (PC + 5) @(negedge clk);

    // R3 glitch filter: short and exact lengths
    busWrite(1, 0, 0, GC - 1, -1, 0); check("R3 short pulse", startCnt, 0);
    busWrite(1, 0, 0, GC, -1, 0);     check("R3 exact pulse", startCnt, 1);
    busWrite(2, 1, 0, GC + 4, -1, 0); check("R3 long pulse once", startCnt, 1);

    // R2 inhibit: oeN low during write
    startCnt = 0; opKind = 3'd1; ceN = 0; weN = 0; oeN = 0;
    repeat (GC + 2) @(negedge clk);
    ceN = 1; weN = 1; oeN = 1; opKind = 0; repeat (3) @(negedge clk);
    check("R2 oeN low inhibits", startCnt, 0);
    // R2 break in middle restarts filter
    startCnt = 0; opKind = 3'd1; ceN = 0; weN = 0;
    repeat (GC - 1) @(negedge clk);
    weN = 1; @(negedge clk); weN = 0;
    repeat (GC - 1) @(negedge clk);
    ceN = 1; weN = 1; opKind = 0; repeat (3) @(negedge clk);
    check("R2 broken strobe restarts", startCnt, 0);

    // R11 codes 0 and 5..7 never start
    busWrite(0, 0, 0, GC + 1, -1, 0); check("R11 code0", startCnt, 0);
    busWrite(6, 0, 0, GC + 1, -1, 0); check("R11 code6", startCnt, 0);

    // R6 lock sector 2; no startEn
    busWrite(4, 2, 0, GC, -1, 0); modelLock[2] = 1;
    check("R6 lock no start", startCnt, 0);
    check("R6 lock bit set", lockBits, 4);
    // R7 program locked refused, unlocked accepted, override accepted
    busWrite(1, 2, 5, GC, -1, 0); check("R7 locked program", startCnt, 0);
    busWrite(2, 3, 0, GC, -1, 0); check("R7 unlocked erase", startCnt, 1);
    hvOverride = 1;
    busWrite(1, 2, 0, GC, -1, 0); check("R7 override program", startCnt, 1);
    // R8 chip erase
    busWrite(3, 0, 0, GC, -1, 0); check("R8 chip erase override", startCnt, 1);
    hvOverride = 0;
    busWrite(3, 0, 0, GC, -1, 0); check("R8 chip erase refused", startCnt, 0);
    // R9 override released at the judging edge
    hvOverride = 1;
    busWrite(1, 2, 0, GC, GC - 1, 0); check("R9 drop at decision", startCnt, 0);
    busWrite(1, 2, 0, GC, GC - 1, 1); check("R9 raise at decision", startCnt, 1);
    hvOverride = 0;

    // R10 identification reads
    idRead(2, 2, v, l); check("R11 normal mode no status", v, 0);
    pulse(1);
    idRead(2, 2, v, l); check("R10 valid", v, 1); check("R10 locked", l, 1);
    idRead(1, 2, v, l); check("R10 valid s1", v, 1); check("R10 unlocked", l, 0);
    idRead(2, 3, v, l); check("R10 other offset", v, 0);
    pulse(0);
    idRead(2, 2, v, l); check("R11 after exit", v, 0);

    // R4 supply low: no start, no lock
    supplyOk = 0; @(negedge clk);
    busWrite(2, 1, 0, GC + 1, -1, 0); check("R4 erase supply low", startCnt, 0);
    busWrite(4, 1, 0, GC + 1, -1, 0); check("R4 lock supply low", lockBits[1], 0);
    // R5 hold-off after rise
    supplyOk = 1;
    busWrite(2, 1, 0, GC, -1, 0); check("R5 inside holdoff", startCnt, 0);
    repeat (PC) @(negedge clk);
    busWrite(2, 1, 0, GC, -1, 0); check("R5 after holdoff", startCnt, 1);

    // Random mix checked against the bench model
    for (int n = 0; n < 80; n++) begin
      op = int'($urandom_range(0, 6));
      sec = int'($urandom_range(0, NS - 1));
      len = int'($urandom_range(1, GC + 3));
      ovr = ($urandom_range(0, 3) == 0);
      hvOverride = ovr;
      e = expStarts(op, sec, len, ovr);
      busWrite(op, sec, int'($urandom_range(0, 7)), len, -1, ovr);
      if (op == 4 && len >= GC) modelLock[sec] = 1;
      check("R7/R8 random start", startCnt, e);
      for (int i = 0; i < NS; i++) check("R6 random lock", lockBits[i], modelLock[i]);
    end
    hvOverride = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule